// File: doc/BRIEF.md
# GPIO Bank with Per-Pin Interrupt Detection

This block serves a bank of general-purpose pins. Every pin owns one control word that sets its direction, output value and pull, and that selects which pad activity raises a pending flag. Five trigger modes are available: rising edge, falling edge, either edge, low level and high level. Pending flags are also gathered into a single bank status word. One bank interrupt line is raised whenever a pin is both pending and enabled.

Pad levels pass through a two-stage synchronizer before detection. Software acknowledges a pin by writing its control word back with the status bit set. A separate ownership register decides which pins are handed to GPIO use. It has one address that sets bits and another that clears them. All access goes through a simple synchronous register port: writes take effect on the clock edge and reads are combinational.

Top module: `gpio_bank`

## Requirements
- R1: After reset, every control word, the bank status word and the ownership register read 0, and pad_oe_o, pad_o, the pull outputs, pad_sel_o and irq_o are all 0.
- R2: Pin n's control word is at word address n. Bits 0..7 are read/write: bit0 low-select, bit1 high-select, bit2 edge-mode, bit3 interrupt enable, bit4 pull enable, bit5 pull-up select, bit6 output enable, bit7 output value. Bits 10..31 read as 0.
- R3: Bit 8 of a control word shows the pad level delayed by two clock edges through the synchronizer. Writes to bit 8 have no effect.
- R4: pad_oe_o[n] follows bit6 of pin n's word, and pad_o[n] follows bit7.
- R5: When bit4 is 1, bit5=1 asserts pull_up_o[n] and bit5=0 asserts pull_dn_o[n]. When bit4 is 0, both pull outputs are 0.
- R6: With bit2=1, a pin goes pending on a synchronized rising edge if bit1=1, and on a synchronized falling edge if bit0=1. Setting both bits gives either-edge detection. An edge-set flag stays set until it is cleared.
- R7: With bit2=0, a pin is pending on every cycle its synchronized level is high (bit1=1) or low (bit0=1). While that level persists, a clear has no lasting effect.
- R8: Bit 9 of a control word is the pin's pending flag. Writing the word with bit9=1 clears the flag, and writing with bit9=0 leaves it as it is. If a new detection falls in the same cycle as a clear, the flag stays set.
- R9: Address NPINS holds the read-only bank status word, in which bit n is pin n's pending flag. Writes to this address change nothing.
- R10: irq_o is 1 exactly when at least one pin has both its pending flag and its bit3 set.
- R11: A write to address NPINS+1 sets the ownership bits that are 1 in the data. A write to NPINS+2 clears the ownership bits that are 1 in the data. Zero bits leave ownership unchanged. Both addresses read the ownership value, which also drives pad_sel_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Word address |
| we_i | input | 1 | Write strobe |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Combinational read data |
| pad_i | input | NPINS | Pad input levels |
| pad_o | output | NPINS | Pad output values |
| pad_oe_o | output | NPINS | Pad output enables |
| pull_up_o | output | NPINS | Pull-up enables |
| pull_dn_o | output | NPINS | Pull-down enables |
| pad_sel_o | output | NPINS | Pins handed to GPIO use |
| irq_o | output | 1 | Bank interrupt |

## Verification
The two functions that can meet in one cycle are a fresh detection and a software clear of the same pin's pending flag. The bench sets up this collision by writing the clear on the exact edge at which a synchronized rising edge reaches the detector, and it expects the flag to survive. The same rule is tested with a held level-mode input, where the clear must not drop the flag. A sweep then rotates all eight mode encodings across all 32 pins with several pad patterns, and compares the status word and irq_o against values computed from the old and new pad words.

// File: rtl/gpio_bank_pkg.sv
`timescale 1ns/1ps
package gpio_bank_pkg;
  localparam int CTRL_W = 10;
  localparam int CFG_W  = 8;
  localparam int BIT_DI = 8;
  localparam int BIT_ST = 9;

  // field order fixes the word layout, bit7 down to bit0
  typedef struct packed {
    logic dout;
    logic oe;
    logic pull_up;
    logic pull_en;
    logic ie;
    logic edge_md;
    logic sel_hi;
    logic sel_lo;
  } pin_cfg_t;
endpackage

// File: rtl/gpio_sync.sv
`timescale 1ns/1ps
module gpio_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_pin.sv
`timescale 1ns/1ps
module gpio_pin
  import gpio_bank_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              din_i,
  input  logic              wr_i,
  input  logic [CTRL_W-1:0] wdata_i,
  output pin_cfg_t          cfg_o,
  output logic              stat_o
);
  pin_cfg_t cfg_q;
  logic     prev_q, stat_q, hit;

  always_comb begin
    if (cfg_q.edge_md)
      hit = (cfg_q.sel_hi & din_i & ~prev_q) | (cfg_q.sel_lo & ~din_i & prev_q);
    else
      hit = (cfg_q.sel_hi & din_i) | (cfg_q.sel_lo & ~din_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      prev_q <= 1'b0;
      stat_q <= 1'b0;
    end else begin
      if (wr_i) cfg_q <= pin_cfg_t'(wdata_i[CFG_W-1:0]);
      prev_q <= din_i;
      // a detection wins over a clear in the same cycle
      stat_q <= (stat_q & ~(wr_i & wdata_i[BIT_ST])) | hit;
    end
  end

  assign cfg_o  = cfg_q;
  assign stat_o = stat_q;
endmodule

// File: rtl/gpio_bank.sv
`timescale 1ns/1ps
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int NPINS  = 32,
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [NPINS-1:0]  pad_i,
  output logic [NPINS-1:0]  pad_o,
  output logic [NPINS-1:0]  pad_oe_o,
  output logic [NPINS-1:0]  pull_up_o,
  output logic [NPINS-1:0]  pull_dn_o,
  output logic [NPINS-1:0]  pad_sel_o,
  output logic              irq_o
);
  localparam int IDX_W = (NPINS > 1) ? $clog2(NPINS) : 1;
  localparam logic [ADDR_W-1:0] PIN_END = ADDR_W'(NPINS);
  localparam logic [ADDR_W-1:0] STAT_A  = ADDR_W'(NPINS);
  localparam logic [ADDR_W-1:0] SET_A   = ADDR_W'(NPINS + 1);
  localparam logic [ADDR_W-1:0] CLR_A   = ADDR_W'(NPINS + 2);

  logic [NPINS-1:0]  din_vec, stat_vec, ie_vec, sel_q;
  logic [DATA_W-1:0] ctrl_rd [NPINS];
  pin_cfg_t          cfg [NPINS];

  gpio_sync #(.W(NPINS), .STAGES(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pad_i),
    .q_o   (din_vec)
  );

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    gpio_pin u_pin (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .din_i  (din_vec[i]),
      .wr_i   (we_i && addr_i == ADDR_W'(i)),
      .wdata_i(wdata_i[CTRL_W-1:0]),
      .cfg_o  (cfg[i]),
      .stat_o (stat_vec[i])
    );
    assign ctrl_rd[i]   = DATA_W'({stat_vec[i], din_vec[i], cfg[i]});
    assign ie_vec[i]    = cfg[i].ie;
    assign pad_o[i]     = cfg[i].dout;
    assign pad_oe_o[i]  = cfg[i].oe;
    assign pull_up_o[i] = cfg[i].pull_en & cfg[i].pull_up;
    assign pull_dn_o[i] = cfg[i].pull_en & ~cfg[i].pull_up;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        sel_q <= '0;
    else if (we_i && addr_i == SET_A)   sel_q <= sel_q | wdata_i[NPINS-1:0];
    else if (we_i && addr_i == CLR_A)   sel_q <= sel_q & ~wdata_i[NPINS-1:0];
  end

  always_comb begin
    if (addr_i < PIN_END)                      rdata_o = ctrl_rd[addr_i[IDX_W-1:0]];
    else if (addr_i == STAT_A)                 rdata_o = DATA_W'(stat_vec);
    else if (addr_i == SET_A || addr_i == CLR_A) rdata_o = DATA_W'(sel_q);
    else                                       rdata_o = '0;
  end

  assign pad_sel_o = sel_q;
  assign irq_o     = |(stat_vec & ie_vec);
endmodule

// File: rtl/gpio_bank_chk.sv
`timescale 1ns/1ps
module gpio_bank_chk #(
  parameter int NPINS  = 32,
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              we_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [NPINS-1:0]  pad_i,
  input logic [NPINS-1:0]  pad_oe_o,
  input logic [NPINS-1:0]  pad_sel_o,
  input logic              irq_o,
  input logic [NPINS-1:0]  din_i,
  input logic [NPINS-1:0]  ie_i
);
  localparam logic [ADDR_W-1:0] SET_A = ADDR_W'(NPINS + 1);
  localparam logic [ADDR_W-1:0] CLR_A = ADDR_W'(NPINS + 2);

  logic [1:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  // R11
  sel_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == SET_A) |=> ((pad_sel_o & $past(wdata_i[NPINS-1:0])) == $past(wdata_i[NPINS-1:0])));
  // R11
  sel_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == CLR_A) |=> ((pad_sel_o & $past(wdata_i[NPINS-1:0])) == '0));
  // R11
  sel_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && (addr_i == SET_A || addr_i == CLR_A)) |=> $stable(pad_sel_o));
  // R4
  oe_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == '0) |=> (pad_oe_o[0] == $past(wdata_i[6])));
  // R3
  sync_delay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd3) |-> (din_i == $past(pad_i, 2)));
  // R10
  irq_enable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (ie_i != '0));
endmodule

bind gpio_bank gpio_bank_chk #(.NPINS(NPINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .addr_i   (addr_i),
  .we_i     (we_i),
  .wdata_i  (wdata_i),
  .pad_i    (pad_i),
  .pad_oe_o (pad_oe_o),
  .pad_sel_o(pad_sel_o),
  .irq_o    (irq_o),
  .din_i    (din_vec),
  .ie_i     (ie_vec)
);

// File: tb/gpio_bank_tb.sv
`timescale 1ns/1ps
module gpio_bank_tb;
  localparam int N = 32;
  localparam logic [5:0] STAT_A = 6'd32;
  localparam logic [5:0] SET_A  = 6'd33;
  localparam logic [5:0] CLR_A  = 6'd34;

  logic clk = 1'b0, rst_n = 1'b0, we = 1'b0, done = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0, rdata, pad = '0;
  logic [31:0] pad_out, pad_oe, pu, pd, psel;
  logic        irq;
  int nchk = 0, nfail = 0;

  always #5 clk = ~clk;

  gpio_bank u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .pad_i(pad), .pad_o(pad_out), .pad_oe_o(pad_oe),
    .pull_up_o(pu), .pull_dn_o(pd), .pad_sel_o(psel), .irq_o(irq)
  );

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; we = 1'b1; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // mode m: bit0 low-select, bit1 high-select, bit2 edge-mode; bit3 ie on odd pins
  function automatic logic [31:0] cfgw(int n, int r);
    logic [2:0] m = 3'((n + r) % 8);
    return {28'd0, (n % 2) == 1, m};
  endfunction

  function automatic logic [31:0] expect_st(int r, logic [31:0] a, logic [31:0] b);
    logic [31:0] e = '0;
    for (int n = 0; n < N; n++) begin
      logic [2:0] m = 3'((n + r) % 8);
      if (m[2]) e[n] = (m[1] & ~a[n] & b[n]) | (m[0] & a[n] & ~b[n]);
      else      e[n] = (m[1] & a[n]) | (m[0] & ~a[n]) | (m[1] & b[n]) | (m[0] & ~b[n]);
    end
    return e;
  endfunction

  initial begin
    #1_000_000;
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1 reset state
    rd(6'd0, v);   chk("R1 word0", v, 0);
    rd(STAT_A, v); chk("R1 status", v, 0);
    rd(SET_A, v);  chk("R1 sel", v, 0);
    chk("R1 outputs", pad_oe | pad_out | pu | pd | psel | 32'(irq), 0);

    // R2 R4 R5 layout and outputs
    wr(6'd5, 32'hFFFF_FFFF);
    rd(6'd5, v); chk("R2 rw bits", v, 32'h0000_00FF);
    chk("R4 oe", pad_oe, 32'h20);
    chk("R4 out", pad_out, 32'h20);
    chk("R5 pull up", {pu[5], pd[5]}, 2'b10);
    wr(6'd5, 32'h10);
    chk("R5 pull down", {pu[5], pd[5], pad_oe[5]}, 3'b010);
    wr(6'd5, 32'h20);
    chk("R5 pull off", {pu[5], pd[5]}, 2'b00);
    wr(6'd5, 32'h0);

    // R3 two-edge synchronizer, bit8 read-only
    @(negedge clk); pad[5] = 1'b1;
    rd(6'd5, v); chk("R3 one edge", v, 32'h0);
    rd(6'd5, v); chk("R3 two edges", v, 32'h100);
    wr(6'd5, 32'h0);
    rd(6'd5, v); chk("R3 write ignored", v, 32'h100);

    // R11 ownership set/clear
    wr(SET_A, 32'hF0); rd(SET_A, v); chk("R11 set", v, 32'hF0);
    chk("R11 pad_sel_o", psel, 32'hF0);
    wr(CLR_A, 32'h30); rd(CLR_A, v); chk("R11 clear", v, 32'hC0);
    wr(SET_A, 32'h0);  wr(CLR_A, 32'h0); rd(SET_A, v); chk("R11 zero bits", v, 32'hC0);

    // R6 R9 R10 rising edge on pin 2
    wr(6'd2, 32'h0E);
    @(negedge clk); pad[2] = 1'b1;
    repeat (4) @(posedge clk);
    rd(STAT_A, v); chk("R6 rise pending", v, 32'h4);
    chk("R10 irq on", 32'(irq), 1);
    wr(STAT_A, 32'h0); wr(STAT_A, 32'hFFFF_FFFF);
    rd(STAT_A, v); chk("R9 write ignored", v, 32'h4);
    wr(6'd2, 32'h06);
    rd(STAT_A, v); chk("R8 bit9 zero keeps", v, 32'h4);
    chk("R10 irq masked", 32'(irq), 0);
    wr(6'd2, 32'h206);
    rd(STAT_A, v); chk("R8 clear", v, 32'h0);

    // R8 clear and detection on the same edge
    @(negedge clk); pad[2] = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk); pad[2] = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk); addr = 6'd2; we = 1'b1; wdata = 32'h206;
    @(negedge clk); we = 1'b0;
    rd(STAT_A, v); chk("R8 set wins", v, 32'h4);
    rd(6'd2, v);   chk("R8 bit9 mirror", v & 32'h200, 32'h200);
    wr(6'd2, 32'h206);
    rd(STAT_A, v); chk("R6 edge cleared", v, 32'h0);

    // R7 held level survives a clear
    wr(6'd2, 32'h02);
    repeat (2) @(posedge clk);
    wr(6'd2, 32'h202);
    rd(STAT_A, v); chk("R7 level held", v, 32'h4);
    @(negedge clk); pad[2] = 1'b0;
    repeat (4) @(posedge clk);
    wr(6'd2, 32'h202);
    rd(STAT_A, v); chk("R7 level gone", v, 32'h0);

    // sweep: every mode on every pin, several pad patterns
    for (int r = 0; r < 8; r++) begin
      for (int n = 0; n < N; n++) wr(6'(n), cfgw(n, r));
      for (int p = 0; p < 3; p++) begin
        logic [31:0] a, b, e;
        if (p == 0)      begin a = '0; b = '1; end
        else if (p == 1) begin a = '1; b = '0; end
        else             begin a = $urandom; b = $urandom; end
        @(negedge clk); pad = a;
        repeat (4) @(posedge clk);
        for (int n = 0; n < N; n++) wr(6'(n), cfgw(n, r) | 32'h200);
        pad = b;
        repeat (4) @(posedge clk);
        e = expect_st(r, a, b);
        rd(STAT_A, v); chk("R6 R7 sweep status", v, e);
        chk("R10 sweep irq", 32'(irq), 32'(|(e & 32'hAAAA_AAAA)));
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule